// File: doc/BRIEF.md
# Quadrature NCO Phase Generator

This block produces the 32-bit phase argument that drives a downstream sine/cosine stage of a numerically controlled oscillator. Each clock it accumulates a tuning word, modulo 2^32, into a phase accumulator. The tuning word is either the center frequency alone or the center frequency plus an offset frequency. The output adds two terms to the accumulated phase: a 16-bit phase offset aligned to the upper half of the phase, and a 3-bit PSK symbol aligned to the top three bits. The PSK term gives eight phase states, 45 degrees apart.

A 16-bit write port loads the registers. Each frequency word goes into a staging register one 16-bit half at a time. A load strobe then copies both staging registers into the active registers in the same cycle. Switching the offset frequency on or off never disturbs the accumulator, so a frequency hop keeps the phase continuous. A synchronous clear and an accumulate enable control the accumulator. A valid flag travels through the two-stage pipeline alongside the phase.

Top module: `nco_phase_gen`

## Requirements
- R1: After a synchronous reset, `phase_arg` is 0 and `phase_valid` is 0. All staging, active, control and phase offset registers are 0.
- R2: With `we_cfreq` (or `we_ofreq`) high, `wr_data` goes into the staging center (or offset) word. `wr_hi`=0 writes bits 15:0 and `wr_hi`=1 writes bits 31:16. A staging write alone does not change the accumulation.
- R3: A cycle with `frq_load` high copies both staging words into the active words. The next accumulation uses them.
- R4: In a cycle with `acc_en` high and `acc_clr` low, the accumulator gains the selected tuning word. With both low, the accumulator holds its value.
- R5: The control register is written with `we_ctrl`. Bit 0 of `wr_data` is the offset enable: when it is 1, the tuning word is center + offset. Changing this bit leaves the accumulator value untouched.
- R6: The phase offset register is written from `wr_data` with `we_phase`. It adds (offset << 16) to the output phase, starting with the output two edges after the write.
- R7: Control bit 1 is the PSK enable. When it is 1, the output phase gains `psk_sym` << 29, so each step of the symbol is 45 degrees. When it is 0, `psk_sym` has no effect.
- R8: When `acc_clr` is high, the accumulator becomes 0 at that edge, whatever `acc_en` is.
- R9: `phase_arg` after edge t+1 equals the accumulator after edge t, plus the phase offset register, plus the PSK term sampled at edge t. `phase_valid` equals `acc_en` from two cycles earlier.
- R10: Every addition wraps modulo 2^32, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 16 | Write data for all registers |
| wr_hi | input | 1 | Half select for frequency writes: 0 writes the low half, 1 writes the high half |
| we_cfreq | input | 1 | Write enable for the staging center frequency |
| we_ofreq | input | 1 | Write enable for the staging offset frequency |
| we_ctrl | input | 1 | Write enable for the control register (bit0 offset enable, bit1 PSK enable) |
| we_phase | input | 1 | Write enable for the phase offset register |
| frq_load | input | 1 | Copies the staging frequencies into the active registers |
| acc_clr | input | 1 | Synchronous accumulator clear |
| acc_en | input | 1 | Accumulate enable, also the valid input |
| psk_sym | input | 3 | PSK phase state |
| phase_arg | output | 32 | Phase argument |
| phase_valid | output | 1 | Valid flag aligned with phase_arg |

## Verification
On every cycle, the assertions check the accumulator update rules: stepping by the selected tuning word, holding while idle, and clearing. They also check that the active frequency words stay put unless the load strobe is high, and that the valid flag lags its input by exactly two cycles. The bench scenarios cover the rest: the half-word staging, the phase-continuous offset hop, the aligned phase offset and PSK terms, the PSK enable gating the symbol, and wraparound. These all show up only in the values seen at `phase_arg`.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int BUS_W   = 16;
    localparam int PHASE_W = 32;
    localparam int POFF_W  = 16;
    localparam int PSK_W   = 3;
    localparam int N_FREQ  = 2;
    localparam int HALF_W  = PHASE_W / 2;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [POFF_W-1:0]  poff_t;
    typedef logic [PSK_W-1:0]   psk_t;

    typedef struct packed {
        logic psk_on;
        logic ofs_on;
    } ctrl_t;

    typedef enum logic [0:0] {
        SLOT_CENTER = 1'b0,
        SLOT_OFFSET = 1'b1
    } slot_e;

    function automatic phase_t align_poff(input poff_t p);
        return {p, {(PHASE_W-POFF_W){1'b0}}};
    endfunction

    function automatic phase_t align_psk(input psk_t s);
        return {s, {(PHASE_W-PSK_W){1'b0}}};
    endfunction
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             wr_hi,
    input  logic             we_cfreq,
    input  logic             we_ofreq,
    input  logic             we_ctrl,
    input  logic             we_phase,
    input  logic             frq_load,
    output phase_t           cf_act,
    output phase_t           of_act,
    output phase_t           freq_sel,
    output ctrl_t            ctrl,
    output poff_t            poff
);
    logic [N_FREQ-1:0] we_vec;
    phase_t            act [N_FREQ];

    assign we_vec[SLOT_CENTER] = we_cfreq;
    assign we_vec[SLOT_OFFSET] = we_ofreq;

    for (genvar k = 0; k < N_FREQ; k++) begin : g_slot
        phase_t stg_q, act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q <= '0;
                act_q <= '0;
            end else begin
                if (we_vec[k]) begin
                    if (wr_hi) stg_q[PHASE_W-1:HALF_W] <= wr_data;
                    else       stg_q[HALF_W-1:0]       <= wr_data;
                end
                if (frq_load) act_q <= stg_q;
            end
        end
        assign act[k] = act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            poff <= '0;
        end else begin
            if (we_ctrl)  ctrl <= ctrl_t'(wr_data[1:0]);
            if (we_phase) poff <= wr_data;
        end
    end

    assign cf_act   = act[SLOT_CENTER];
    assign of_act   = act[SLOT_OFFSET];
    assign freq_sel = cf_act + (ctrl.ofs_on ? of_act : '0);
endmodule

// File: rtl/nco_accum.sv
module nco_accum
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   en,
    input  phase_t freq,
    output phase_t acc_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else if (en)    acc_q <= acc_q + freq;
    end
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  psk_t   psk_sym,
    input  logic   psk_on,
    input  phase_t acc_q,
    input  poff_t  poff,
    output phase_t phase_arg,
    output logic   phase_valid
);
    psk_t psk_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psk_q       <= '0;
            vld_q       <= 1'b0;
            phase_arg   <= '0;
            phase_valid <= 1'b0;
        end else begin
            psk_q       <= psk_on ? psk_sym : '0;
            vld_q       <= en;
            phase_arg   <= acc_q + align_poff(poff) + align_psk(psk_q);
            phase_valid <= vld_q;
        end
    end
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
    import nco_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               wr_hi,
    input  logic               we_cfreq,
    input  logic               we_ofreq,
    input  logic               we_ctrl,
    input  logic               we_phase,
    input  logic               frq_load,
    input  logic               acc_clr,
    input  logic               acc_en,
    input  logic [PSK_W-1:0]   psk_sym,
    output logic [PHASE_W-1:0] phase_arg,
    output logic               phase_valid
);
    phase_t cf_act, of_act, freq_sel, acc_q;
    ctrl_t  ctrl;
    poff_t  poff;

    nco_regfile u_regs (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_hi(wr_hi),
        .we_cfreq(we_cfreq), .we_ofreq(we_ofreq), .we_ctrl(we_ctrl),
        .we_phase(we_phase), .frq_load(frq_load),
        .cf_act(cf_act), .of_act(of_act), .freq_sel(freq_sel),
        .ctrl(ctrl), .poff(poff)
    );

    nco_accum u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .en(acc_en),
        .freq(freq_sel), .acc_q(acc_q)
    );

    nco_phase_out u_out (
        .clk(clk), .rst(rst), .en(acc_en), .psk_sym(psk_sym),
        .psk_on(ctrl.psk_on), .acc_q(acc_q), .poff(poff),
        .phase_arg(phase_arg), .phase_valid(phase_valid)
    );
endmodule

// File: rtl/nco_phase_gen_chk.sv
module nco_phase_gen_chk
    import nco_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   acc_en,
    input logic   acc_clr,
    input logic   frq_load,
    input logic   phase_valid,
    input phase_t acc_q,
    input phase_t freq_sel,
    input phase_t cf_act,
    input phase_t of_act
);
    logic [1:0] since_rst;
    logic       en_d1, en_d2;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
        en_d1 <= acc_en;
        en_d2 <= en_d1;
    end

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_clr) |=> acc_q == $past(acc_q) + $past(freq_sel));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !acc_clr) |=> $stable(acc_q));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> acc_q == '0);

    p_no_load_r3: assert property (@(posedge clk) disable iff (rst)
        !frq_load |=> ($stable(cf_act) && $stable(of_act)));

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd3) |-> phase_valid == en_d2);
endmodule

bind nco_phase_gen nco_phase_gen_chk u_chk (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_clr(acc_clr),
    .frq_load(frq_load), .phase_valid(phase_valid), .acc_q(acc_q),
    .freq_sel(freq_sel), .cf_act(cf_act), .of_act(of_act)
);

// File: tb/nco_phase_gen_tb.sv
module nco_phase_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] wr_data;
    logic        wr_hi, we_cfreq, we_ofreq, we_ctrl, we_phase, frq_load;
    logic        acc_clr, acc_en;
    logic [2:0]  psk_sym;
    logic [31:0] phase_arg;
    logic        phase_valid;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [31:0] m_stg_c, m_stg_o, m_act_c, m_act_o, m_acc, m_out;
    logic [1:0]  m_ctrl;
    logic [15:0] m_poff;
    logic [2:0]  m_psk_q;
    logic        m_v1, m_v2;

    always #2 clk = ~clk;

    nco_phase_gen u_dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_hi(wr_hi),
        .we_cfreq(we_cfreq), .we_ofreq(we_ofreq), .we_ctrl(we_ctrl),
        .we_phase(we_phase), .frq_load(frq_load), .acc_clr(acc_clr),
        .acc_en(acc_en), .psk_sym(psk_sym), .phase_arg(phase_arg),
        .phase_valid(phase_valid)
    );

    function automatic logic [31:0] f_freq(input logic [31:0] c, input logic [31:0] o,
                                           input logic ofs);
        return c + (ofs ? o : 32'h0);
    endfunction

    function automatic logic [31:0] f_phase(input logic [31:0] acc, input logic [15:0] p,
                                            input logic [2:0] s);
        return acc + {p, 16'h0} + {s, 29'h0};
    endfunction

    task automatic idle_inputs();
        wr_data = '0; wr_hi = 0; we_cfreq = 0; we_ofreq = 0; we_ctrl = 0;
        we_phase = 0; frq_load = 0; acc_clr = 0; acc_en = 0; psk_sym = '0;
    endtask

    task automatic model_edge();
        logic [31:0] n_out, n_acc;
        n_out = f_phase(m_acc, m_poff, m_psk_q);
        if (rst) begin
            m_stg_c = 0; m_stg_o = 0; m_act_c = 0; m_act_o = 0; m_acc = 0;
            m_out = 0; m_ctrl = 0; m_poff = 0; m_psk_q = 0; m_v1 = 0; m_v2 = 0;
            return;
        end
        if (acc_clr)     n_acc = 0;
        else if (acc_en) n_acc = m_acc + f_freq(m_act_c, m_act_o, m_ctrl[0]);
        else             n_acc = m_acc;
        m_out   = n_out;
        m_v2    = m_v1;
        m_v1    = acc_en;
        m_psk_q = m_ctrl[1] ? psk_sym : 3'd0;
        m_acc   = n_acc;
        if (frq_load) begin m_act_c = m_stg_c; m_act_o = m_stg_o; end
        if (we_cfreq) begin
            if (wr_hi) m_stg_c[31:16] = wr_data; else m_stg_c[15:0] = wr_data;
        end
        if (we_ofreq) begin
            if (wr_hi) m_stg_o[31:16] = wr_data; else m_stg_o[15:0] = wr_data;
        end
        if (we_ctrl)  m_ctrl = wr_data[1:0];
        if (we_phase) m_poff = wr_data;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // inputs are set at a negedge; one edge applied; outputs compared at the next negedge
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(req, phase_arg, m_out, "phase_arg");
        chk(req, {31'h0, phase_valid}, {31'h0, m_v2}, "phase_valid");
        idle_inputs();
    endtask

    task automatic wr_freq(input logic ofs, input logic [31:0] v, input string req);
        we_cfreq = !ofs; we_ofreq = ofs; wr_hi = 0; wr_data = v[15:0]; step(req);
        we_cfreq = !ofs; we_ofreq = ofs; wr_hi = 1; wr_data = v[31:16]; step(req);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin acc_en = 1; step(req); end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        rst = 1;
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        chk("R1", phase_arg, 32'h0, "reset phase");
        chk("R1", {31'h0, phase_valid}, 32'h0, "reset valid");

        // R2: staging write alone leaves the phase at zero
        wr_freq(0, 32'h0001_2345, "R2");
        run(3, "R2");
        chk("R2", phase_arg, 32'h0, "no load yet");

        // R3/R4: load, then accumulate
        frq_load = 1; step("R3");
        run(4, "R3");
        chk("R4", phase_arg, 32'h0001_2345 * 3, "accumulated");
        step("R4"); step("R4"); step("R4");   // hold with enable low

        // R5: offset hop keeps phase continuous
        wr_freq(1, 32'h0000_1000, "R5");
        frq_load = 1; step("R5");
        we_ctrl = 1; wr_data = 16'h0001; step("R5");
        run(3, "R5");
        we_ctrl = 1; wr_data = 16'h0000; step("R5");
        run(3, "R5");

        // R6: phase offset
        we_phase = 1; wr_data = 16'h4000; step("R6");
        step("R6"); step("R6");

        // R7: PSK disabled then enabled
        psk_sym = 3'd5; step("R7"); step("R7");
        we_ctrl = 1; wr_data = 16'h0002; step("R7");
        for (int s = 0; s < 8; s++) begin psk_sym = 3'(s); step("R7"); end
        step("R7"); step("R7");

        // R8: clear beats enable
        acc_clr = 1; acc_en = 1; step("R8");
        step("R8"); step("R8");

        // R10: wraparound
        wr_freq(0, 32'hC000_0001, "R10");
        frq_load = 1; step("R10");
        we_phase = 1; wr_data = 16'hFFFF; step("R10");
        psk_sym = 3'd7; run(6, "R10");

        // R9: valid and latency under random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r        = 4'($urandom);
            acc_en   = $urandom_range(0, 3) != 0;
            acc_clr  = ($urandom_range(0, 40) == 0);
            psk_sym  = 3'($urandom);
            wr_data  = 16'($urandom);
            wr_hi    = r[0];
            we_cfreq = (r[3:1] == 3'd1);
            we_ofreq = (r[3:1] == 3'd2);
            we_ctrl  = (r[3:1] == 3'd3);
            we_phase = (r[3:1] == 3'd4);
            frq_load = ($urandom_range(0, 7) == 0);
            step("R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule